// File: doc/BRIEF.md
# Speculative Register Rename with Retirement Copy

This block renames destination registers for an out-of-order core that keeps its speculative results in the reorder buffer. An alias table holds one entry per architectural register. Each entry says whether the register's newest value is in the committed register file or is owed by a reorder-buffer slot. Up to `RW` instructions are renamed in each cycle. For every source operand the block returns where the value lives, the slot tag when the value is still owed, and the value itself when it is already known.

Results enter the reorder-buffer data array when they are written back. The oldest slot retires once its result is present, and its value is then copied into the committed register file. At that point the alias entry goes back to the committed file, but only if it still names the retiring slot. A mispredicted branch is handled by a full flush when the branch retires. The flush empties the reorder buffer and points every alias entry back at the committed file.

Top module: `rob_rename_unit`

## Requirements
- R1: Reset leaves every register at value 0, every alias entry pointing at the committed file, the reorder buffer empty, `ren_ready` high and the next tag at 0.
- R2: A source whose register maps to the committed file reports `op_in_rob`=0 and `op_ready`=1, with `op_data` equal to the committed value.
- R3: A group of valid slots (lowest index oldest) takes consecutive tags starting at the buffer tail. Invalid slots consume no tag. A later source of that register reports `op_in_rob`=1, the allocated tag and `op_ready`=0.
- R4: After a slot's result is written back, a source mapped to that slot reports `op_ready`=1 with the written value. A writeback to that tag in the same cycle is forwarded to the source.
- R5: Slots retire oldest first, at most one per cycle, once their result is present. Each retirement presents tag, register and value, and copies the value into the committed file.
- R6: A retirement points the alias entry back at the committed file only when that entry still holds the retiring tag. A newer mapping of the register survives.
- R7: The source of slot i that names the destination of an older valid slot j<i in the same group gets slot j's tag, not ready, taking the newest such j. When several slots of a group name one register, the youngest mapping is the one left in the alias table.
- R8: `ren_ready` is low while fewer than `RW` buffer slots are free. While it is low, no slot is allocated and the alias table is unchanged.
- R9: In a flush cycle nothing retires and renames are ignored. After it, every alias entry points at the committed file, the buffer is empty with next tag 0, and committed values are kept.
- R10: Consecutive retirements carry consecutive tags, modulo the buffer depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | RW | Per-slot rename request, slot 0 oldest |
| ren_dst | input | RW x log2(AREG_N) | Destination register per slot |
| ren_src | input | RW x 2 x log2(AREG_N) | Two source registers per slot |
| ren_ready | output | 1 | At least RW buffer slots free; requests are accepted |
| ren_tag | output | RW x log2(ROB_N) | Tag allocated to each valid slot |
| op_in_rob | output | RW x 2 | Source value comes from a buffer slot |
| op_tag | output | RW x 2 x log2(ROB_N) | Buffer slot owing the source value |
| op_ready | output | RW x 2 | Source value is available now |
| op_data | output | RW x 2 x DATA_W | Source value when ready, else 0 |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | log2(ROB_N) | Slot being written back |
| wb_data | input | DATA_W | Result value |
| flush | input | 1 | Full recovery flush |
| ret_valid | output | 1 | Oldest slot retires this cycle |
| ret_tag | output | log2(ROB_N) | Tag of the retiring slot |
| ret_areg | output | log2(AREG_N) | Register written by the retiring slot |
| ret_data | output | DATA_W | Value copied into the committed file |

## Verification
The rename stimulus covers several cases:
- A pair whose second slot reads the first slot's destination, which separates forwarding within a group from an alias-table lookup.
- A pair whose second slot reads its own destination, which must still see the old mapping.
- A single rename in the upper slot, which shows whether invalid slots consume tags.
- Two slots naming the same register, which shows which slot's mapping is kept.

Writebacks are issued in three ways:
- In the same cycle as a lookup, which isolates the forwarding path.
- Oldest first, ahead of a newer writer of the same register, which separates a tag-matched release from an unconditional one.
- In fully reverse order, which shows whether retirement waits for the head.

Filling the buffer to its last slot, then flushing while a retirement and a rename are both pending, tests that the block refuses allocation when full and that the flush takes priority.

// File: rtl/rn_pkg.sv
package rn_pkg;
   // where a resolved source operand is found
   typedef enum logic [1:0] {
      LOC_ARF      = 2'd0,
      LOC_ROB_WAIT = 2'd1,
      LOC_ROB_DONE = 2'd2,
      LOC_GROUP    = 2'd3
   } src_loc_e;

   localparam int SRC_PER_OP = 2;
endpackage

// File: rtl/rn_arf.sv
module rn_arf #(
   parameter  int AREG_N = 32,
   parameter  int DATA_W = 32,
   parameter  int RD_N   = 4,
   localparam int AW     = $clog2(AREG_N)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [AW-1:0]                waddr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [RD_N-1:0][AW-1:0]      raddr,
   output logic [RD_N-1:0][DATA_W-1:0]  rdata
);
   logic [AREG_N-1:0][DATA_W-1:0] regs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (we) begin
         regs_q[waddr] <= wdata;
      end
   end

   always_comb begin
      for (int p = 0; p < RD_N; p++) begin
         rdata[p] = regs_q[raddr[p]];
      end
   end
endmodule

// File: rtl/rn_rob.sv
module rn_rob #(
   parameter  int ROB_N  = 128,
   parameter  int DATA_W = 32,
   parameter  int AREG_N = 32,
   parameter  int RW     = 2,
   parameter  int RD_N   = 4,
   localparam int TW     = $clog2(ROB_N),
   localparam int AW     = $clog2(AREG_N),
   localparam int CW     = TW + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic [RW-1:0]                slot_valid,
   input  logic                         alloc_go,
   input  logic [RW-1:0][AW-1:0]        alloc_areg,
   output logic [RW-1:0][TW-1:0]        alloc_tag,
   output logic                         room_ok,
   input  logic                         wb_valid,
   input  logic [TW-1:0]                wb_tag,
   input  logic [DATA_W-1:0]            wb_data,
   input  logic [RD_N-1:0][TW-1:0]      rd_tag,
   output logic [RD_N-1:0][DATA_W-1:0]  rd_data,
   output logic                         ret_valid,
   output logic [TW-1:0]                ret_tag,
   output logic [AW-1:0]                ret_areg,
   output logic [DATA_W-1:0]            ret_data
);
   logic [TW-1:0]     head_q, tail_q;
   logic [CW-1:0]     cnt_q;
   logic [ROB_N-1:0]  done_q;
   logic [DATA_W-1:0] data_mem [ROB_N];
   logic [AW-1:0]     areg_mem [ROB_N];
   logic [CW-1:0]     n_alloc;

   // compacted tags: only valid slots advance the tail
   always_comb begin
      n_alloc = '0;
      for (int i = 0; i < RW; i++) begin
         alloc_tag[i] = tail_q + TW'(n_alloc);
         if (slot_valid[i]) n_alloc = n_alloc + CW'(1);
      end
   end

   assign room_ok   = (cnt_q <= CW'(ROB_N - RW));
   assign ret_valid = (cnt_q != '0) && done_q[head_q] && !flush;
   assign ret_tag   = head_q;
   assign ret_areg  = areg_mem[head_q];
   assign ret_data  = data_mem[head_q];

   always_comb begin
      for (int p = 0; p < RD_N; p++) begin
         rd_data[p] = data_mem[rd_tag[p]];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         done_q <= '0;
      end else begin
         if (wb_valid) done_q[wb_tag] <= 1'b1;
         if (alloc_go) begin
            for (int i = 0; i < RW; i++) begin
               if (slot_valid[i]) done_q[alloc_tag[i]] <= 1'b0;
            end
            tail_q <= tail_q + TW'(n_alloc);
         end
         if (ret_valid) head_q <= head_q + TW'(1);
         cnt_q <= cnt_q + (alloc_go ? n_alloc : CW'(0)) - CW'(ret_valid);
      end
   end

   // payload arrays carry no reset; done bits qualify them
   always_ff @(posedge clk) begin
      if (wb_valid && !flush) data_mem[wb_tag] <= wb_data;
      if (alloc_go) begin
         for (int i = 0; i < RW; i++) begin
            if (slot_valid[i]) areg_mem[alloc_tag[i]] <= alloc_areg[i];
         end
      end
   end
endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
   parameter  int AREG_N = 32,
   parameter  int ROB_N  = 128,
   parameter  int RW     = 2,
   localparam int TW     = $clog2(ROB_N),
   localparam int AW     = $clog2(AREG_N)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic [RW-1:0]               alloc_en,
   input  logic [RW-1:0][AW-1:0]       alloc_dst,
   input  logic [RW-1:0][TW-1:0]       alloc_tag,
   input  logic                        wb_valid,
   input  logic [TW-1:0]               wb_tag,
   input  logic                        ret_valid,
   input  logic [TW-1:0]               ret_tag,
   input  logic [AW-1:0]               ret_areg,
   output logic [AREG_N-1:0]           at_in_rob,
   output logic [AREG_N-1:0]           at_ready,
   output logic [AREG_N-1:0][TW-1:0]   at_tag
);
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         at_in_rob <= '0;
         at_ready  <= '0;
         at_tag    <= '0;
      end else begin
         for (int r = 0; r < AREG_N; r++) begin
            if (wb_valid && at_in_rob[r] && at_tag[r] == wb_tag) at_ready[r] <= 1'b1;
         end
         // release only when the entry still names the retiring slot
         if (ret_valid && at_in_rob[ret_areg] && at_tag[ret_areg] == ret_tag) begin
            at_in_rob[ret_areg] <= 1'b0;
            at_ready[ret_areg]  <= 1'b0;
         end
         // renames last: youngest slot wins, and beats a release
         for (int i = 0; i < RW; i++) begin
            if (alloc_en[i]) begin
               at_in_rob[alloc_dst[i]] <= 1'b1;
               at_ready[alloc_dst[i]]  <= 1'b0;
               at_tag[alloc_dst[i]]    <= alloc_tag[i];
            end
         end
      end
   end
endmodule

// File: rtl/rob_rename_unit.sv
module rob_rename_unit
   import rn_pkg::*;
#(
   parameter  int AREG_N = 32,
   parameter  int ROB_N  = 128,
   parameter  int DATA_W = 32,
   parameter  int RW     = 2,
   localparam int AW     = $clog2(AREG_N),
   localparam int TW     = $clog2(ROB_N),
   localparam int RD_N   = RW * SRC_PER_OP
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [RW-1:0]                            ren_valid,
   input  logic [RW-1:0][AW-1:0]                    ren_dst,
   input  logic [RW-1:0][SRC_PER_OP-1:0][AW-1:0]    ren_src,
   output logic                                     ren_ready,
   output logic [RW-1:0][TW-1:0]                    ren_tag,
   output logic [RW-1:0][SRC_PER_OP-1:0]            op_in_rob,
   output logic [RW-1:0][SRC_PER_OP-1:0][TW-1:0]    op_tag,
   output logic [RW-1:0][SRC_PER_OP-1:0]            op_ready,
   output logic [RW-1:0][SRC_PER_OP-1:0][DATA_W-1:0] op_data,
   input  logic                                     wb_valid,
   input  logic [TW-1:0]                            wb_tag,
   input  logic [DATA_W-1:0]                        wb_data,
   input  logic                                     flush,
   output logic                                     ret_valid,
   output logic [TW-1:0]                            ret_tag,
   output logic [AW-1:0]                            ret_areg,
   output logic [DATA_W-1:0]                        ret_data
);
   if ((ROB_N & (ROB_N - 1)) != 0) begin : g_bad_depth
      $error("ROB_N must be a power of two");
   end
   if (RW < 1 || RW > ROB_N) begin : g_bad_width
      $error("RW must lie in 1..ROB_N");
   end
   if (AREG_N < 2 || DATA_W < 1) begin : g_bad_regs
      $error("AREG_N must be at least 2 and DATA_W at least 1");
   end

   logic                         alloc_go;
   logic [RW-1:0]                alloc_en;
   logic [RW-1:0][TW-1:0]        alloc_tag;
   logic                         room_ok;
   logic [AREG_N-1:0]            at_in_rob, at_ready;
   logic [AREG_N-1:0][TW-1:0]    at_tag;
   logic [RD_N-1:0][AW-1:0]      arf_raddr;
   logic [RD_N-1:0][DATA_W-1:0]  arf_rdata;
   logic [RD_N-1:0][TW-1:0]      rob_rtag;
   logic [RD_N-1:0][DATA_W-1:0]  rob_rdata;

   assign ren_ready = room_ok;
   assign alloc_go  = room_ok && !flush;
   assign alloc_en  = ren_valid & {RW{alloc_go}};
   assign ren_tag   = alloc_tag;

   rn_rob #(.ROB_N(ROB_N), .DATA_W(DATA_W), .AREG_N(AREG_N), .RW(RW), .RD_N(RD_N)) u_rob (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .slot_valid(ren_valid), .alloc_go(alloc_go), .alloc_areg(ren_dst),
      .alloc_tag(alloc_tag), .room_ok(room_ok),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .rd_tag(rob_rtag), .rd_data(rob_rdata),
      .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_areg(ret_areg), .ret_data(ret_data)
   );

   rn_alias_table #(.AREG_N(AREG_N), .ROB_N(ROB_N), .RW(RW)) u_alias (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc_en(alloc_en), .alloc_dst(ren_dst), .alloc_tag(alloc_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag),
      .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_areg(ret_areg),
      .at_in_rob(at_in_rob), .at_ready(at_ready), .at_tag(at_tag)
   );

   rn_arf #(.AREG_N(AREG_N), .DATA_W(DATA_W), .RD_N(RD_N)) u_arf (
      .clk(clk), .rst_n(rst_n),
      .we(ret_valid), .waddr(ret_areg), .wdata(ret_data),
      .raddr(arf_raddr), .rdata(arf_rdata)
   );

   for (genvar gi = 0; gi < RW; gi++) begin : g_slot
      for (genvar gs = 0; gs < SRC_PER_OP; gs++) begin : g_src
         localparam int P = gi * SRC_PER_OP + gs;
         logic          grp_hit;
         logic [TW-1:0] grp_tag;
         logic [AW-1:0] sreg;
         src_loc_e      loc;

         assign sreg         = ren_src[gi][gs];
         assign arf_raddr[P] = sreg;
         assign rob_rtag[P]  = at_tag[sreg];

         // older slots of the same group, newest match kept
         always_comb begin
            grp_hit = 1'b0;
            grp_tag = '0;
            for (int j = 0; j < gi; j++) begin
               if (ren_valid[j] && ren_dst[j] == sreg) begin
                  grp_hit = 1'b1;
                  grp_tag = alloc_tag[j];
               end
            end
         end

         always_comb begin
            if (grp_hit)                                            loc = LOC_GROUP;
            else if (!at_in_rob[sreg])                              loc = LOC_ARF;
            else if (at_ready[sreg] || (wb_valid && wb_tag == at_tag[sreg])) loc = LOC_ROB_DONE;
            else                                                    loc = LOC_ROB_WAIT;
         end

         always_comb begin
            op_in_rob[gi][gs] = 1'b1;
            op_tag[gi][gs]    = at_tag[sreg];
            op_ready[gi][gs]  = 1'b0;
            op_data[gi][gs]   = '0;
            case (loc)
               LOC_GROUP: op_tag[gi][gs] = grp_tag;
               LOC_ARF: begin
                  op_in_rob[gi][gs] = 1'b0;
                  op_tag[gi][gs]    = '0;
                  op_ready[gi][gs]  = 1'b1;
                  op_data[gi][gs]   = arf_rdata[P];
               end
               LOC_ROB_DONE: begin
                  op_ready[gi][gs] = 1'b1;
                  op_data[gi][gs]  = at_ready[sreg] ? rob_rdata[P] : wb_data;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
   parameter  int AREG_N = 32,
   parameter  int ROB_N  = 128,
   parameter  int RW     = 2,
   localparam int AW     = $clog2(AREG_N),
   localparam int TW     = $clog2(ROB_N)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [RW-1:0]               ren_valid,
   input logic [RW-1:0][AW-1:0]       ren_dst,
   input logic [RW-1:0][1:0][AW-1:0]  ren_src,
   input logic                        ren_ready,
   input logic [RW-1:0][TW-1:0]       ren_tag,
   input logic [RW-1:0][1:0]          op_in_rob,
   input logic [RW-1:0][1:0][TW-1:0]  op_tag,
   input logic [RW-1:0][1:0]          op_ready,
   input logic                        flush,
   input logic                        ret_valid,
   input logic [TW-1:0]               ret_tag
);
   // R9: recovery cycle retires nothing
   a_r9_no_retire_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !ret_valid);

   // R9 / R1: buffer empty after a flush, slot 0 source back on the committed file
   a_r9_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ren_ready && ren_tag[0] == '0 && !op_in_rob[0][0]));

   // R10: retirement tags advance by one
   a_r10_ret_sequence: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |=> (!ret_valid || ret_tag == TW'($past(ret_tag) + 1'b1)));

   // R8: no allocation while short of room
   a_r8_full_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (!ren_ready && !flush) |=> (ren_tag[0] == $past(ren_tag[0])));

   for (genvar i = 0; i < RW; i++) begin : g_op
      for (genvar s = 0; s < 2; s++) begin : g_s
         // R2: committed-file sources are always available
         a_r2_arf_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
            !op_in_rob[i][s] |-> op_ready[i][s]);
      end
      if (i > 0) begin : g_pair
         // R3: adjacent valid slots get consecutive tags
         a_r3_consecutive_tags: assert property (@(posedge clk) disable iff (!rst_n)
            (ren_valid[i] && ren_valid[i-1]) |-> (ren_tag[i] == TW'(ren_tag[i-1] + 1'b1)));
         // R7: source matching the next-older slot's destination
         a_r7_group_forward: assert property (@(posedge clk) disable iff (!rst_n)
            (ren_valid[i] && ren_valid[i-1] && ren_src[i][0] == ren_dst[i-1])
            |-> (op_in_rob[i][0] && op_tag[i][0] == ren_tag[i-1] && !op_ready[i][0]));
      end
   end
endmodule

bind rob_rename_unit rn_checker #(.AREG_N(AREG_N), .ROB_N(ROB_N), .RW(RW)) u_rn_chk (
   .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_dst(ren_dst), .ren_src(ren_src),
   .ren_ready(ren_ready), .ren_tag(ren_tag), .op_in_rob(op_in_rob), .op_tag(op_tag),
   .op_ready(op_ready), .flush(flush), .ret_valid(ret_valid), .ret_tag(ret_tag)
);

// File: tb/rob_rename_unit_bench.sv
module rob_rename_unit_bench;
   localparam int AREG_N = 32, ROB_N = 128, DATA_W = 32, RW = 2;
   localparam int AW = 5, TW = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [RW-1:0] ren_valid;
   logic [RW-1:0][AW-1:0] ren_dst;
   logic [RW-1:0][1:0][AW-1:0] ren_src;
   logic ren_ready;
   logic [RW-1:0][TW-1:0] ren_tag;
   logic [RW-1:0][1:0] op_in_rob, op_ready;
   logic [RW-1:0][1:0][TW-1:0] op_tag;
   logic [RW-1:0][1:0][DATA_W-1:0] op_data;
   logic wb_valid, flush, ret_valid;
   logic [TW-1:0] wb_tag, ret_tag;
   logic [DATA_W-1:0] wb_data, ret_data;
   logic [AW-1:0] ret_areg;

   always #5 clk = ~clk;

   rob_rename_unit #(.AREG_N(AREG_N), .ROB_N(ROB_N), .DATA_W(DATA_W), .RW(RW)) u_rob_rename_unit (
      .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_dst(ren_dst), .ren_src(ren_src),
      .ren_ready(ren_ready), .ren_tag(ren_tag), .op_in_rob(op_in_rob), .op_tag(op_tag),
      .op_ready(op_ready), .op_data(op_data), .wb_valid(wb_valid), .wb_tag(wb_tag),
      .wb_data(wb_data), .flush(flush), .ret_valid(ret_valid), .ret_tag(ret_tag),
      .ret_areg(ret_areg), .ret_data(ret_data)
   );

   int vectors = 0, fails = 0, seq = 0, exp_tail = 0;
   logic [TW+AW+DATA_W-1:0] exp_q [$];
   logic [DATA_W-1:0] pdata [ROB_N];
   logic [DATA_W-1:0] arf_model [AREG_N];
   int lastw [AREG_N];

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic clear_in();
      ren_valid = '0; wb_valid = 1'b0; flush = 1'b0;
   endtask

   // driver: records a rename the design is expected to accept
   task automatic note_ren(int slot);
      logic [TW-1:0] t;
      t = TW'(exp_tail);
      seq++;
      pdata[t] = 32'h5A00_0000 + DATA_W'(seq) * 32'h0001_0101;
      exp_q.push_back({t, ren_dst[slot], pdata[t]});
      lastw[ren_dst[slot]] = exp_tail;
      exp_tail = (exp_tail + 1) % ROB_N;
   endtask

   task automatic wb_go(int tag);
      wb_valid = 1'b1; wb_tag = TW'(tag); wb_data = pdata[tag];
   endtask

   // slot 0 source lookup checked mid-cycle, then advance and clear
   task automatic probe(int r, bit e_in, int e_tag, bit e_rdy, logic [31:0] e_data, string req);
      ren_src[0][0] = AW'(r);
      @(negedge clk);
      chk(req, $sformatf("in_rob r%0d", r), 32'(op_in_rob[0][0]), 32'(e_in));
      chk(req, $sformatf("ready r%0d", r), 32'(op_ready[0][0]), 32'(e_rdy));
      if (e_in) chk(req, $sformatf("tag r%0d", r), 32'(op_tag[0][0]), 32'(e_tag));
      if (e_rdy) chk(req, $sformatf("data r%0d", r), op_data[0][0], e_data);
      step(); clear_in();
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step();
   endtask

   // monitor: each retirement must match the oldest expected item (R5, R10)
   always @(negedge clk) begin
      if (rst_n && ret_valid) begin
         if (exp_q.size() == 0) begin
            chk("R5", "unexpected retire tag", 32'(ret_tag), 32'hFFFF_FFFF);
         end else begin
            logic [TW+AW+DATA_W-1:0] e;
            e = exp_q.pop_front();
            chk("R10", "retire tag", 32'(ret_tag), 32'(e[TW+AW+DATA_W-1 -: TW]));
            chk("R5", "retire areg", 32'(ret_areg), 32'(e[AW+DATA_W-1 -: AW]));
            chk("R5", "retire data", ret_data, e[DATA_W-1:0]);
            arf_model[e[AW+DATA_W-1 -: AW]] = e[DATA_W-1:0];
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      automatic int pairs [12] = '{9, 9, 1, 2, 2, 1, 30, 31, 9, 0, 5, 5};
      for (int r = 0; r < AREG_N; r++) begin arf_model[r] = '0; lastw[r] = 0; end
      clear_in(); ren_dst = '0; ren_src = '0; wb_tag = '0; wb_data = '0;
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;

      // R1 / R2: reset state and committed-file lookup
      @(negedge clk);
      chk("R1", "ren_ready", 32'(ren_ready), 1);
      chk("R1", "first tag", 32'(ren_tag[0]), 0);
      probe(5, 0, 0, 1, 32'h0, "R2");

      // R3 / R7: pair; slot 1 reads slot 0 dst and its own dst
      ren_valid = 2'b11; ren_dst[0] = 3; ren_dst[1] = 4;
      ren_src[0][0] = 3; ren_src[1][0] = 3; ren_src[1][1] = 4;
      note_ren(0); note_ren(1);
      @(negedge clk);
      chk("R3", "slot0 tag", 32'(ren_tag[0]), 0);
      chk("R3", "slot1 tag", 32'(ren_tag[1]), 1);
      chk("R7", "grp in_rob", 32'(op_in_rob[1][0]), 1);
      chk("R7", "grp tag", 32'(op_tag[1][0]), 0);
      chk("R7", "grp ready", 32'(op_ready[1][0]), 0);
      chk("R7", "own dst old map", 32'(op_in_rob[1][1]), 0);
      chk("R2", "slot0 arf", 32'(op_in_rob[0][0]), 0);
      step(); clear_in();

      // R3: only slot 1 valid, takes tag 2
      ren_valid = 2'b10; ren_dst[1] = 3; ren_src[1][0] = 3; ren_src[1][1] = 4;
      note_ren(1);
      @(negedge clk);
      chk("R3", "lone slot tag", 32'(ren_tag[1]), 2);
      chk("R3", "src r3 tag", 32'(op_tag[1][0]), 0);
      chk("R3", "src r4 tag", 32'(op_tag[1][1]), 1);
      chk("R3", "src r4 pending", 32'(op_ready[1][1]), 0);
      step(); clear_in();

      // R4: same-cycle forward, then stored value
      wb_go(1);
      probe(4, 1, 1, 1, pdata[1], "R4");
      probe(4, 1, 1, 1, pdata[1], "R4");

      // R5 / R6: head written back; r3 keeps newer mapping, r4 released
      wb_go(0); step(); clear_in();
      idle(3);
      probe(3, 1, 2, 0, 32'h0, "R6");
      probe(4, 0, 0, 1, pdata[1], "R5");
      wb_go(2); step(); clear_in();
      idle(3);
      probe(3, 0, 0, 1, pdata[2], "R5");

      // R8: fill to capacity
      for (int k = 0; k < ROB_N / 2; k++) begin
         ren_valid = 2'b11; ren_dst[0] = AW'(2 * k); ren_dst[1] = AW'(2 * k + 1);
         note_ren(0); note_ren(1);
         step(); clear_in();
      end
      ren_valid = 2'b11; ren_dst[0] = 7; ren_dst[1] = 7;
      @(negedge clk);
      chk("R8", "ren_ready when full", 32'(ren_ready), 0);
      step(); clear_in();
      probe(7, 1, lastw[7], 0, 32'h0, "R8");

      // R9: flush wins over a pending retirement and a rename
      wb_go(3); step(); clear_in();
      flush = 1'b1; ren_valid = 2'b11; ren_dst[0] = 10; ren_dst[1] = 11;
      exp_q.delete(); exp_tail = 0;
      @(negedge clk);
      chk("R9", "no retire in flush", 32'(ret_valid), 0);
      step(); clear_in();
      @(negedge clk);
      chk("R9", "ready after flush", 32'(ren_ready), 1);
      chk("R9", "tag restart", 32'(ren_tag[0]), 0);
      probe(10, 0, 0, 1, arf_model[10], "R9");
      probe(7, 0, 0, 1, arf_model[7], "R9");
      probe(4, 0, 0, 1, arf_model[4], "R9");

      // stream: same-dst pair, reverse writeback, in-order retire
      for (int k = 0; k < 6; k++) begin
         ren_valid = 2'b11; ren_dst[0] = AW'(pairs[2*k]); ren_dst[1] = AW'(pairs[2*k+1]);
         note_ren(0); note_ren(1);
         step(); clear_in();
         if (k == 0) probe(9, 1, 1, 0, 32'h0, "R7");
      end
      for (int t = 11; t >= 0; t--) begin
         wb_go(t); step(); clear_in();
      end
      idle(16);
      chk("R5", "all retired", 32'(exp_q.size()), 0);
      for (int k = 0; k < 12; k++) probe(pairs[k], 0, 0, 1, arf_model[pairs[k]], "R5");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule